// File: doc/BRIEF.md
# Configurable Sum-of-Products Macrocell

This block models one output cell of a small programmable logic device in synthesizable form. A set of configuration registers, written through a load strobe, holds 16 product-term masks and a handful of mode flags. Each mask selects true or complement literals from the array inputs. Eight terms build the logic function. The other eight are paired into four control signals: output enable, preset, clear and a cell-local clock.

The eight logic terms form a lower and an upper group of four. Either group can be handed to a neighbouring cell, and groups handed over by neighbours can be added in. The sum either drives the pin directly or feeds a storage element. That element can be set up as a D, T, JK or SR flip-flop. An inversion bit sets the pin polarity. Two feedback values return to the array: one taken inside the cell and one taken from the pin after the output buffer.

The design is fully synchronous. The clock edges of the device are represented by the `gclk_tick` strobe, or by a rising edge of the clock term, sampled on `clk`.

Top module: `sop_macrocell`

## Requirements
- R1: A cycle with `rst` high clears the storage bit and every configuration field to zero. After reset `pin_oe`, `pin_out`, `fb_int`, `to_prev` and `to_next` are 0.
- R2: Array signal 0 is `gclk_tick` and signal i (i ≥ 1) is `arr_in[i-1]`. Literal 2i is signal i and literal 2i+1 is its complement. A product term is the AND of the literals set in its mask, and a term whose mask is empty is 0. Logic terms 0–3 form the lower group and terms 4–7 the upper group, each mask LW bits wide at offset t·LW. The logic sum is the OR of the groups in use.
- R3: `pin_out` is the output node (the sum when bypassed, otherwise the stored bit) XOR the invert flag.
- R4: With give_lo set, the OR of the lower group leaves on `to_prev` and is dropped locally. With give_hi set, the same applies to the upper group and `to_next`. With take_prev or take_next set, `from_prev` joins the lower group or `from_next` joins the upper group.
- R5: On a clock event, mode 0 (D) loads the sum and mode 1 (T) toggles the bit when the sum is 1.
- R6: Modes 2 (JK) and 3 (SR) take J or S from the lower group and K or R from the upper group. Only one input asserted sets or clears the bit. JK with both inputs asserted toggles, and SR with both asserted holds.
- R7: Control terms 2–3 (preset) set the bit and terms 4–5 (clear) reset it in the following cycle, without any clock event. Clear wins over preset, and both win over a clock event.
- R8: With clk_pt at 0, the register is clocked by `gclk_tick` and literals 0 and 1 read as 0 in every term. With clk_pt at 1, `gclk_tick` is an ordinary array signal.
- R9: With clk_pt at 1, a clock event is a cycle in which control terms 6–7 OR to 1 after having been 0 in the previous cycle. `gclk_tick` then does not clock the register.
- R10: `pin_oe` is the oe_force flag OR control terms 0–1. `pin_fb` equals `pin_out` while `pin_oe` is 1 and `pin_ext` while it is 0.
- R11: `fb_int` is the node before inversion, or always the stored bit when fb_reg is set.
- R12: Configuration inputs take effect only in the cycle after a `cfg_load` edge. Flag bits are: mode [1:0], give_lo 2, give_hi 3, take_prev 4, take_next 5, invert 6, bypass 7, clk_pt 8, fb_reg 9, oe_force 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up clear) |
| cfg_load | input | 1 | Capture the configuration inputs |
| cfg_logic_mask | input | 8·LW | Masks of the eight logic terms |
| cfg_ctrl_mask | input | 8·LW | Masks of the eight control terms |
| cfg_flags | input | 11 | Mode flags (layout in R12) |
| gclk_tick | input | 1 | Global clock event, also array signal 0 |
| arr_in | input | N_IN | Array input signals |
| from_prev | input | 1 | Group lent by the previous cell |
| from_next | input | 1 | Group lent by the next cell |
| pin_ext | input | 1 | Value driven onto the pin from outside |
| to_prev | output | 1 | Lower group lent to the previous cell |
| to_next | output | 1 | Upper group lent to the next cell |
| pin_out | output | 1 | Output buffer data |
| pin_oe | output | 1 | Output buffer enable |
| pin_fb | output | 1 | Feedback taken at the pin |
| fb_int | output | 1 | Internal feedback |

## Verification
The hardest state to reach is a clock event that comes from the product-term clock rather than the global strobe. It needs a clock term that was low in the previous cycle and high now, while the global strobe is raised at the same time and must be ignored. The stimulus reaches it by resetting and loading a configuration in which one array input alone drives the clock term. That input is walked low, high, high with the strobe pulsing, and low again. The same route drives the clock term from the global strobe as a literal. Each register mode is also run for long random stretches against a next-state model.

// File: rtl/sop_cell_pkg.sv
package sop_cell_pkg;
  localparam int GROUP_TERMS = 4;
  localparam int LOGIC_TERMS = 2 * GROUP_TERMS;
  localparam int CTRL_TERMS  = 8;
  localparam int CT_OE  = 0;
  localparam int CT_PRE = 2;
  localparam int CT_CLR = 4;
  localparam int CT_CLK = 6;

  typedef enum logic [1:0] {
    MODE_D  = 2'd0,
    MODE_T  = 2'd1,
    MODE_JK = 2'd2,
    MODE_SR = 2'd3
  } sop_mode_e;

  typedef struct packed {
    logic      oe_force;
    logic      fb_reg;
    logic      clk_pt;
    logic      bypass;
    logic      invert;
    logic      take_next;
    logic      take_prev;
    logic      give_hi;
    logic      give_lo;
    sop_mode_e mode;
  } sop_flags_t;

  localparam int FLAGS_W = $bits(sop_flags_t);
endpackage

// File: rtl/sop_cell_cfg.sv
module sop_cell_cfg
  import sop_cell_pkg::*;
#(
  parameter int LW = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [LOGIC_TERMS*LW-1:0] logic_mask_in,
  input  logic [CTRL_TERMS*LW-1:0]  ctrl_mask_in,
  input  logic [FLAGS_W-1:0]        flags_in,
  output logic [LOGIC_TERMS*LW-1:0] logic_mask,
  output logic [CTRL_TERMS*LW-1:0]  ctrl_mask,
  output sop_flags_t                flags
);
  always_ff @(posedge clk) begin
    if (rst) begin
      logic_mask <= '0;
      ctrl_mask  <= '0;
      flags      <= '0;
    end else if (load) begin
      logic_mask <= logic_mask_in;
      ctrl_mask  <= ctrl_mask_in;
      flags      <= sop_flags_t'(flags_in);
    end
  end

  // R12: configuration only moves on a load strobe
  a_r12_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(logic_mask) && $stable(ctrl_mask) && $stable(flags)));
endmodule

// File: rtl/sop_term_array.sv
module sop_term_array #(
  parameter int LW = 10,
  parameter int NT = 8
) (
  input  logic [LW-1:0]    lits,
  input  logic [NT*LW-1:0] masks,
  output logic [NT-1:0]    terms
);
  for (genvar t = 0; t < NT; t++) begin : g_term
    logic [LW-1:0] m;
    assign m        = masks[t*LW +: LW];
    assign terms[t] = (|m) & (&(lits | ~m));
  end
endmodule

// File: rtl/sop_cell_reg.sv
module sop_cell_reg
  import sop_cell_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  sop_mode_e mode,
  input  logic      tick,
  input  logic      d_in,
  input  logic      lo_in,
  input  logic      hi_in,
  input  logic      pre,
  input  logic      clr,
  output logic      q
);
  logic nxt;

  always_comb begin
    case (mode)
      MODE_D:  nxt = d_in;
      MODE_T:  nxt = q ^ d_in;
      MODE_JK: case ({lo_in, hi_in})
                 2'b10:   nxt = 1'b1;
                 2'b01:   nxt = 1'b0;
                 2'b11:   nxt = ~q;
                 default: nxt = q;
               endcase
      MODE_SR: case ({lo_in, hi_in})
                 2'b10:   nxt = 1'b1;
                 2'b01:   nxt = 1'b0;
                 default: nxt = q;
               endcase
      default: nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (clr)  q <= 1'b0;
    else if (pre)  q <= 1'b1;
    else if (tick) q <= nxt;
  end

  a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == 1'b0));
  a_r7_preset_sets: assert property (@(posedge clk) disable iff (rst)
    (pre && !clr) |=> (q == 1'b1));
  a_r5_d_loads: assert property (@(posedge clk) disable iff (rst)
    (tick && !pre && !clr && mode == MODE_D) |=> (q == $past(d_in)));
  a_r6_sr_hold: assert property (@(posedge clk) disable iff (rst)
    (tick && !pre && !clr && mode == MODE_SR && lo_in && hi_in) |=> $stable(q));
  a_r6_jk_toggle: assert property (@(posedge clk) disable iff (rst)
    (tick && !pre && !clr && mode == MODE_JK && lo_in && hi_in) |=> (q != $past(q)));
  a_r9_no_event_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !pre && !clr) |=> $stable(q));
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
  import sop_cell_pkg::*;
#(
  parameter int N_IN = 4,
  localparam int NSIG = N_IN + 1,
  localparam int LW   = 2 * NSIG
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_load,
  input  logic [LOGIC_TERMS*LW-1:0] cfg_logic_mask,
  input  logic [CTRL_TERMS*LW-1:0]  cfg_ctrl_mask,
  input  logic [FLAGS_W-1:0]        cfg_flags,
  input  logic                      gclk_tick,
  input  logic [N_IN-1:0]           arr_in,
  input  logic                      from_prev,
  input  logic                      from_next,
  input  logic                      pin_ext,
  output logic                      to_prev,
  output logic                      to_next,
  output logic                      pin_out,
  output logic                      pin_oe,
  output logic                      pin_fb,
  output logic                      fb_int
);
  logic [LOGIC_TERMS*LW-1:0] lmask;
  logic [CTRL_TERMS*LW-1:0]  cmask;
  sop_flags_t                flags;

  sop_cell_cfg #(.LW(LW)) u_cfg (
    .clk(clk), .rst(rst), .load(cfg_load),
    .logic_mask_in(cfg_logic_mask), .ctrl_mask_in(cfg_ctrl_mask),
    .flags_in(cfg_flags),
    .logic_mask(lmask), .ctrl_mask(cmask), .flags(flags)
  );

  // literal vector; the global clock literals die while it clocks the cell
  logic [NSIG-1:0] sig;
  logic [LW-1:0]   lits;
  assign sig = {arr_in, gclk_tick};

  always_comb begin
    for (int i = 0; i < NSIG; i++) begin
      lits[2*i]   = sig[i];
      lits[2*i+1] = ~sig[i];
    end
    if (!flags.clk_pt) begin
      lits[0] = 1'b0;
      lits[1] = 1'b0;
    end
  end

  logic [LOGIC_TERMS-1:0] lt;
  logic [CTRL_TERMS-1:0]  ct;

  sop_term_array #(.LW(LW), .NT(LOGIC_TERMS)) u_logic_terms (
    .lits(lits), .masks(lmask), .terms(lt)
  );
  sop_term_array #(.LW(LW), .NT(CTRL_TERMS)) u_ctrl_terms (
    .lits(lits), .masks(cmask), .terms(ct)
  );

  // group allocation
  logic lo_or, hi_or, lo_use, hi_use, sum;
  assign lo_or  = |lt[GROUP_TERMS-1:0];
  assign hi_or  = |lt[LOGIC_TERMS-1:GROUP_TERMS];
  assign lo_use = (lo_or & ~flags.give_lo) | (from_prev & flags.take_prev);
  assign hi_use = (hi_or & ~flags.give_hi) | (from_next & flags.take_next);
  assign sum    = lo_use | hi_use;
  assign to_prev = lo_or & flags.give_lo;
  assign to_next = hi_or & flags.give_hi;

  // control pairs
  logic oe_t, pre_t, clr_t, clk_t, clk_t_q, tick;
  assign oe_t  = ct[CT_OE]  | ct[CT_OE+1];
  assign pre_t = ct[CT_PRE] | ct[CT_PRE+1];
  assign clr_t = ct[CT_CLR] | ct[CT_CLR+1];
  assign clk_t = ct[CT_CLK] | ct[CT_CLK+1];

  always_ff @(posedge clk) begin
    if (rst) clk_t_q <= 1'b0;
    else     clk_t_q <= clk_t;
  end

  assign tick = flags.clk_pt ? (clk_t & ~clk_t_q) : gclk_tick;

  logic q;
  sop_cell_reg u_reg (
    .clk(clk), .rst(rst), .mode(flags.mode), .tick(tick),
    .d_in(sum), .lo_in(lo_use), .hi_in(hi_use),
    .pre(pre_t), .clr(clr_t), .q(q)
  );

  logic node;
  assign node    = flags.bypass ? sum : q;
  assign pin_out = node ^ flags.invert;
  assign pin_oe  = flags.oe_force | oe_t;
  assign pin_fb  = pin_oe ? pin_out : pin_ext;
  assign fb_int  = flags.fb_reg ? q : node;

  // R9: with the term clock selected, a steady clock term never moves the bit
  a_r9_pt_steady: assert property (@(posedge clk) disable iff (rst)
    (flags.clk_pt && clk_t_q && !pre_t && !clr_t) |=> $stable(q));
endmodule

// File: tb/sop_macrocell_tb.sv
module sop_macrocell_tb;
  import sop_cell_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N_IN = 4;
  localparam int NSIG = N_IN + 1;
  localparam int LW = 2 * NSIG;
  localparam int MW = 8 * LW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_load = 1'b0;
  logic [MW-1:0] cfg_logic_mask = '0;
  logic [MW-1:0] cfg_ctrl_mask = '0;
  logic [FLAGS_W-1:0] cfg_flags = '0;
  logic gclk_tick = 1'b0;
  logic [N_IN-1:0] arr_in = '0;
  logic from_prev = 1'b0, from_next = 1'b0, pin_ext = 1'b0;
  logic to_prev, to_next, pin_out, pin_oe, pin_fb, fb_int;

  int n_checks = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sop_macrocell #(.N_IN(N_IN)) u_dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load),
    .cfg_logic_mask(cfg_logic_mask), .cfg_ctrl_mask(cfg_ctrl_mask),
    .cfg_flags(cfg_flags), .gclk_tick(gclk_tick), .arr_in(arr_in),
    .from_prev(from_prev), .from_next(from_next), .pin_ext(pin_ext),
    .to_prev(to_prev), .to_next(to_next), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_fb(pin_fb), .fb_int(fb_int)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [LW-1:0] mk_lits(input logic [N_IN-1:0] a, input logic g,
                                            input logic live);
    logic [NSIG-1:0] s;
    logic [LW-1:0] l;
    s = {a, g};
    for (int i = 0; i < NSIG; i++) begin
      l[2*i] = s[i];
      l[2*i+1] = ~s[i];
    end
    if (!live) l[1:0] = 2'b00;
    return l;
  endfunction

  function automatic logic [1:0] groups(input logic [MW-1:0] m, input logic [LW-1:0] l);
    logic lo, hi;
    lo = 1'b0; hi = 1'b0;
    for (int t = 0; t < 8; t++) begin
      logic [LW-1:0] mm;
      logic tv;
      mm = m[t*LW +: LW];
      tv = (mm != '0) && ((l & mm) == mm);
      if (t < 4) lo = lo | tv; else hi = hi | tv;
    end
    return {hi, lo};
  endfunction

  function automatic logic [LW-1:0] rmask();
    logic [LW-1:0] m;
    m = LW'($urandom) & LW'($urandom) & LW'($urandom);
    if (m == '0) m[$urandom % LW] = 1'b1;
    return m;
  endfunction

  function automatic logic [MW-1:0] rmasks();
    logic [MW-1:0] m;
    for (int t = 0; t < 8; t++) m[t*LW +: LW] = rmask();
    return m;
  endfunction

  function automatic logic [MW-1:0] one_lit(input int term, input int lit);
    logic [MW-1:0] m;
    m = '0;
    m[term*LW + lit] = 1'b1;
    return m;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; gclk_tick = 1'b0; arr_in = '0;
    from_prev = 1'b0; from_next = 1'b0; pin_ext = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_cfg(input logic [MW-1:0] lm, input logic [MW-1:0] cm,
                          input sop_flags_t f);
    @(negedge clk);
    cfg_logic_mask = lm; cfg_ctrl_mask = cm; cfg_flags = f; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // one register step: drive at negedge, check after the following edge
  task automatic step(input logic [N_IN-1:0] a, input logic g);
    @(negedge clk);
    arr_in = a; gclk_tick = g;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    sop_flags_t f;
    logic [MW-1:0] lm;
    logic [1:0] gr;
    logic exp, mq, lo, hi, s;

    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk("R1 pin_oe", pin_oe, 1'b0);
    chk("R1 pin_out", pin_out, 1'b0);
    chk("R1 fb_int", fb_int, 1'b0);
    chk("R1 to_prev", to_prev, 1'b0);
    chk("R1 to_next", to_next, 1'b0);

    // R2 R3 R8 R10 R11: combinational sweep over all input patterns
    for (int k = 0; k < 8; k++) begin
      lm = rmasks();
      f = '0; f.bypass = 1'b1; f.oe_force = 1'b1;
      f.clk_pt = k[0]; f.invert = k[1];
      load_cfg(lm, '0, f);
      for (int v = 0; v < 32; v++) begin
        logic [4:0] vv;
        vv = 5'(v);
        arr_in = vv[4:1]; gclk_tick = vv[0];
        #1;
        gr = groups(lm, mk_lits(vv[4:1], vv[0], f.clk_pt));
        exp = (gr[0] | gr[1]) ^ f.invert;
        chk("R2/R3 pin_out", pin_out, exp);
        chk("R10 pin_fb", pin_fb, exp);
        chk("R11 fb_int", fb_int, gr[0] | gr[1]);
        @(negedge clk);
      end
    end

    // R8: global clock literal is dead while it clocks the register
    f = '0; f.bypass = 1'b1; f.oe_force = 1'b1;
    load_cfg(one_lit(0, 0), '0, f);
    arr_in = '0; gclk_tick = 1'b1; #1;
    chk("R8 literal gated", pin_out, 1'b0);
    f.clk_pt = 1'b1;
    load_cfg(one_lit(0, 0), '0, f);
    gclk_tick = 1'b1; #1;
    chk("R8 literal live", pin_out, 1'b1);

    // R4: group lending and borrowing
    do_reset();
    f = '0; f.bypass = 1'b1; f.oe_force = 1'b1; f.give_lo = 1'b1;
    load_cfg(one_lit(0, 2) | one_lit(4, 4), '0, f);
    arr_in = 4'b0001; #1;
    chk("R4 to_prev lent", to_prev, 1'b1);
    chk("R4 lower dropped", pin_out, 1'b0);
    arr_in = 4'b0010; #1;
    chk("R4 upper kept", pin_out, 1'b1);
    chk("R4 to_next idle", to_next, 1'b0);
    f = '0; f.bypass = 1'b1; f.oe_force = 1'b1; f.give_hi = 1'b1;
    f.take_prev = 1'b1; f.take_next = 1'b1;
    load_cfg(one_lit(0, 2) | one_lit(4, 4), '0, f);
    arr_in = 4'b0010; #1;
    chk("R4 to_next lent", to_next, 1'b1);
    chk("R4 upper dropped", pin_out, 1'b0);
    from_prev = 1'b1; #1;
    chk("R4 from_prev adds", pin_out, 1'b1);
    from_prev = 1'b0; from_next = 1'b1; #1;
    chk("R4 from_next adds", pin_out, 1'b1);
    from_next = 1'b0;

    // R5 R6: every register mode against a next-state model
    for (int md = 0; md < 4; md++) begin
      do_reset();
      lm = rmasks();
      f = '0; f.oe_force = 1'b1; f.mode = sop_mode_e'(md); f.invert = md[0];
      load_cfg(lm, '0, f);
      mq = 1'b0;
      for (int c = 0; c < 300; c++) begin
        logic [N_IN-1:0] a;
        logic g;
        a = N_IN'($urandom); g = 1'($urandom);
        gr = groups(lm, mk_lits(a, g, 1'b0));
        lo = gr[0]; hi = gr[1]; s = lo | hi;
        if (g) begin
          case (md)
            0: mq = s;
            1: mq = mq ^ s;
            2: mq = (lo && hi) ? ~mq : (lo ? 1'b1 : (hi ? 1'b0 : mq));
            default: mq = (lo && !hi) ? 1'b1 : ((hi && !lo) ? 1'b0 : mq);
          endcase
        end
        step(a, g);
        if (md < 2) chk("R5 stored bit", fb_int, mq);
        else        chk("R6 stored bit", fb_int, mq);
        chk("R3 registered pin", pin_out, mq ^ md[0]);
      end
    end

    // R7: preset, clear, priority
    do_reset();
    f = '0; f.oe_force = 1'b1; f.mode = MODE_D;
    load_cfg(one_lit(0, 2), one_lit(2, 4) | one_lit(4, 6), f);
    step(4'b0010, 1'b0);
    chk("R7 preset no clock", fb_int, 1'b1);
    step(4'b0100, 1'b0);
    chk("R7 clear no clock", fb_int, 1'b0);
    step(4'b0010, 1'b1);
    chk("R7 preset beats clock", fb_int, 1'b1);
    step(4'b0110, 1'b0);
    chk("R7 clear beats preset", fb_int, 1'b0);

    // R9: product-term clock
    do_reset();
    f = '0; f.oe_force = 1'b1; f.mode = MODE_T; f.clk_pt = 1'b1;
    load_cfg(one_lit(0, 2), one_lit(6, 8), f);
    step(4'b0001, 1'b1);
    chk("R9 no edge no change", fb_int, 1'b0);
    step(4'b1001, 1'b0);
    chk("R9 rising edge toggles", fb_int, 1'b1);
    step(4'b1001, 1'b1);
    chk("R9 steady term and gclk ignored", fb_int, 1'b1);
    step(4'b0001, 1'b0);
    step(4'b1001, 1'b0);
    chk("R9 second edge toggles", fb_int, 1'b0);
    // R8: global clock as an array input feeding the term clock
    load_cfg(one_lit(0, 2), one_lit(6, 0), f);
    step(4'b0001, 1'b0);
    step(4'b0001, 1'b1);
    chk("R8 gclk through term clock", fb_int, 1'b1);

    // R10: output enable and pin feedback
    do_reset();
    f = '0; f.bypass = 1'b1;
    load_cfg(one_lit(0, 4), one_lit(0, 2), f);
    arr_in = 4'b0010; pin_ext = 1'b0; #1;
    chk("R10 oe low", pin_oe, 1'b0);
    chk("R10 pin_fb external 0", pin_fb, 1'b0);
    pin_ext = 1'b1; #1;
    chk("R10 pin_fb external 1", pin_fb, 1'b1);
    arr_in = 4'b0001; pin_ext = 1'b1; #1;
    chk("R10 oe high", pin_oe, 1'b1);
    chk("R10 pin_fb driven", pin_fb, 1'b0);
    pin_ext = 1'b0;

    // R11: buried register with combinational pin
    do_reset();
    f = '0; f.bypass = 1'b1; f.oe_force = 1'b1; f.fb_reg = 1'b1;
    load_cfg(one_lit(0, 2), '0, f);
    arr_in = 4'b0001; #1;
    chk("R11 pin combinational", pin_out, 1'b1);
    chk("R11 fb_int holds stored", fb_int, 1'b0);
    step(4'b0001, 1'b1);
    chk("R11 fb_int after load", fb_int, 1'b1);

    // R12: configuration only changes on load
    do_reset();
    f = '0; f.bypass = 1'b1; f.oe_force = 1'b1;
    load_cfg(one_lit(0, 2), '0, f);
    arr_in = 4'b0001;
    f.invert = 1'b1;
    cfg_flags = f;
    @(negedge clk); #1;
    chk("R12 no load no change", pin_out, 1'b1);
    load_cfg(one_lit(0, 2), '0, f);
    #1;
    chk("R12 load applies", pin_out, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule